// File: doc/BRIEF.md
# Zero-Run Silence Detector

This block watches six parallel audio sample streams and drives an active-low silence flag. Each valid frame carries one 24-bit sample per channel. The block counts consecutive valid frames in which every participating channel holds exactly zero. When that count reaches a fixed run length, 9600 frames by default, the flag goes low. At a 48 kHz frame rate that is 200 ms. A mute input forces the flag low at any time, whatever the samples contain.

A control input chooses how channels take part. In pin mode every channel takes part. In register mode a six-bit mask chooses the channels, one bit per channel. Downstream logic can use the flag to mute outputs or to gate recording while no programme material is present.

The sample input is a valid/ready stream. The block never applies back-pressure, so `smp_ready` is high in every cycle after reset. A frame counts in a cycle when `smp_valid` and `smp_ready` are both high. The data lines are ignored in cycles without a transfer.

Top module: `zrun_silence_detect`

## Requirements
- R1: `silence_n` is active low. It is high while reset is asserted and in the first cycle after reset.
- R2: With the participating channels at zero and mute low, `silence_n` goes low on the clock edge that accepts the RUN_LEN-th consecutive all-zero frame. It stays high on every edge before that one.
- R3: When `pin_mode` is 1, all six channels take part and `part_mask` has no effect on detection.
- R4: When `pin_mode` is 0, channel c takes part only if `part_mask[c]` is 1. A non-zero sample on an excluded channel neither resets the run nor raises the flag.
- R5: When `mute_in` is high at a clock edge, `silence_n` is low after that edge, regardless of the samples.
- R6: A transferred frame with a non-zero sample on any participating channel clears the run. If mute is low, `silence_n` is high after that same edge.
- R7: The run advances only on transfers. Idle cycles, whatever their data, neither advance nor clear it. Once the run reaches RUN_LEN it saturates, so further zero frames keep `silence_n` low.
- R8: When `pin_mode` is 0 and `part_mask` is all zeros, `silence_n` stays high unless mute is high.
- R9: A change of `part_mask` or of `pin_mode` between two cycles clears the run, and a frame accepted in that cycle is not counted. Another RUN_LEN zero frames are then needed.
- R10: `smp_ready` is 1 in every cycle after reset. The sample stream is never back-pressured.

Channel c sits at bits `[c*24 +: 24]` of `smp_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Frame valid |
| smp_ready | output | 1 | Frame ready, always high after reset |
| smp_data | input | 144 | Six packed 24-bit samples, channel 0 in the low bits |
| part_mask | input | 6 | Per-channel participation enables (register mode) |
| pin_mode | input | 1 | 1 selects pin mode (all channels), 0 selects register mode |
| mute_in | input | 1 | Mute, forces the flag active |
| silence_n | output | 1 | Silence flag, active low |

## Verification
The checker checks four things on every cycle:
- Mute forces the flag low on the next cycle.
- A participating non-zero transfer raises the flag on the next cycle while mute is low.
- An empty register-mode mask keeps the flag high.
- The run never exceeds its limit and is zero after a configuration change, and a low flag always traces back to mute or to a full run.

Only the bench scenarios show the exact frame on which the flag falls after long zero runs. The same goes for the effect of idle cycles holding non-zero data, excluded channels that carry signal, and the full restart of the run after a mask or mode change.

// File: rtl/zrun_pkg.sv
package zrun_pkg;
  typedef enum logic {
    MODE_REG = 1'b0,
    MODE_PIN = 1'b1
  } ctrl_mode_e;
endpackage

// File: rtl/zrun_zero_flags.sv
module zrun_zero_flags #(
  parameter int NUM_CH = 6,
  parameter int SMP_W  = 24
) (
  input  logic [NUM_CH*SMP_W-1:0] data,
  output logic [NUM_CH-1:0]       nz
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign nz[c] = |data[c*SMP_W +: SMP_W];
  end
endmodule

// File: rtl/zrun_counter.sv
module zrun_counter #(
  parameter int RUN_LEN = 9600,
  parameter int CW      = $clog2(RUN_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic          hit,
  output logic [CW-1:0] cnt_q,
  output logic          full_nxt
);
  localparam logic [CW-1:0] LIMIT = CW'(RUN_LEN);
  logic [CW-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt = cnt_q;
    if (clr)
      cnt_nxt = '0;
    else if (step) begin
      if (hit)
        cnt_nxt = '0;
      else if (cnt_q < LIMIT)
        cnt_nxt = cnt_q + 1'b1;
    end
  end

  assign full_nxt = (cnt_nxt == LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/zrun_silence_detect.sv
module zrun_silence_detect #(
  parameter int NUM_CH  = 6,
  parameter int SMP_W   = 24,
  parameter int RUN_LEN = 9600
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_valid,
  output logic                    smp_ready,
  input  logic [NUM_CH*SMP_W-1:0] smp_data,
  input  logic [NUM_CH-1:0]       part_mask,
  input  logic                    pin_mode,
  input  logic                    mute_in,
  output logic                    silence_n
);
  import zrun_pkg::*;
  localparam int CW = $clog2(RUN_LEN + 1);

  ctrl_mode_e        mode;
  logic [NUM_CH-1:0] eff_mask, nz, mask_prev_q;
  logic              mode_prev_q, cfg_chg, hit, step, full_nxt, ready_q;
  logic [CW-1:0]     run_cnt;

  assign mode     = ctrl_mode_e'(pin_mode);
  assign eff_mask = (mode == MODE_PIN) ? '1 : part_mask;
  assign cfg_chg  = (part_mask != mask_prev_q) || (pin_mode != mode_prev_q);
  assign hit      = |(nz & eff_mask);
  assign step     = smp_valid & smp_ready;
  assign smp_ready = ready_q;

  zrun_zero_flags #(.NUM_CH(NUM_CH), .SMP_W(SMP_W)) u_zero (
    .data (smp_data),
    .nz   (nz)
  );

  zrun_counter #(.RUN_LEN(RUN_LEN), .CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (cfg_chg),
    .step     (step),
    .hit      (hit),
    .cnt_q    (run_cnt),
    .full_nxt (full_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_prev_q <= '0;
      mode_prev_q <= 1'b0;
      ready_q     <= 1'b0;
      silence_n   <= 1'b1;
    end else begin
      mask_prev_q <= part_mask;
      mode_prev_q <= pin_mode;
      ready_q     <= 1'b1;
      silence_n   <= ~(mute_in | ((|eff_mask) & full_nxt));
    end
  end
endmodule

// File: rtl/zrun_silence_chk.sv
module zrun_silence_chk #(
  parameter int NUM_CH  = 6,
  parameter int SMP_W   = 24,
  parameter int RUN_LEN = 9600,
  parameter int CW      = $clog2(RUN_LEN + 1)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    smp_valid,
  input logic                    smp_ready,
  input logic [NUM_CH*SMP_W-1:0] smp_data,
  input logic [NUM_CH-1:0]       part_mask,
  input logic                    pin_mode,
  input logic                    mute_in,
  input logic                    silence_n,
  input logic [CW-1:0]           run_cnt
);
  logic part_nz;
  always_comb begin
    part_nz = 1'b0;
    for (int c = 0; c < NUM_CH; c++)
      if ((pin_mode || part_mask[c]) && (smp_data[c*SMP_W +: SMP_W] != '0))
        part_nz = 1'b1;
  end

  // R5
  mute_forces_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mute_in |=> !silence_n);

  // R6
  nonzero_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready && part_nz && !mute_in) |=> silence_n);

  // R8
  empty_mask_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pin_mode && part_mask == '0 && !mute_in) |=> silence_n);

  // R7
  run_saturates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= CW'(RUN_LEN));

  // R9
  cfg_change_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (part_mask != $past(part_mask) || pin_mode != $past(pin_mode)) |=> run_cnt == '0);

  // R2
  low_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !silence_n |-> ($past(mute_in) || run_cnt == CW'(RUN_LEN)));
endmodule

bind zrun_silence_detect zrun_silence_chk #(
  .NUM_CH(NUM_CH), .SMP_W(SMP_W), .RUN_LEN(RUN_LEN)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .smp_valid (smp_valid),
  .smp_ready (smp_ready),
  .smp_data  (smp_data),
  .part_mask (part_mask),
  .pin_mode  (pin_mode),
  .mute_in   (mute_in),
  .silence_n (silence_n),
  .run_cnt   (run_cnt)
);

// File: tb/test_zrun_silence_detect.sv
module test_zrun_silence_detect;
  localparam int NCH = 6;
  localparam int SW  = 24;
  localparam int RUN = 9600;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic smp_ready;
  logic [NCH*SW-1:0] smp_data = '0;
  logic [NCH-1:0] part_mask = '1;
  logic pin_mode = 1'b0;
  logic mute_in = 1'b0;
  logic silence_n;

  int checks = 0;
  int errors = 0;
  logic  exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  zrun_silence_detect #(.NUM_CH(NCH), .SMP_W(SW), .RUN_LEN(RUN)) i_zrun_silence_detect (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .part_mask(part_mask), .pin_mode(pin_mode),
    .mute_in(mute_in), .silence_n(silence_n)
  );

  function automatic logic [NCH*SW-1:0] one_ch(int ch, logic [SW-1:0] v);
    logic [NCH*SW-1:0] d = '0;
    d[ch*SW +: SW] = v;
    return d;
  endfunction

  task automatic drive(input logic v, input logic [NCH*SW-1:0] d, input logic [NCH-1:0] m,
                       input logic pm, input logic mu, input logic exp, input string tag);
    @(negedge clk);
    smp_valid = v; smp_data = d; part_mask = m; pin_mode = pm; mute_in = mu;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // monitor: pop one expectation per driven cycle, after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(silence_n, e, t);
      end
    end
  end

  initial begin
    #1200000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(silence_n, 1'b1, "R1 reset level");
    rst_n = 1'b1;
    @(negedge clk);
    check(silence_n, 1'b1, "R1 after reset");
    check(smp_ready, 1'b1, "R10 ready high");

    // R2 exact threshold, then R7 saturation, then R6 clear
    for (int k = 1; k <= RUN + 3; k++)
      drive(1, '0, '1, 0, 0, (k >= RUN) ? 1'b0 : 1'b1, "R2/R7 zero run");
    drive(1, one_ch(2, 24'h000001), '1, 0, 0, 1'b1, "R6 nonzero clears");
    drive(1, '0, '1, 0, 0, 1'b1, "R6 run restarted");

    // R7 idle cycles with non-zero data do not touch the run (run is 1 now)
    for (int k = 2; k <= RUN; k++) begin
      if (k == 5000)
        for (int j = 0; j < 3; j++)
          drive(0, one_ch(0, 24'h800000), '1, 0, 0, 1'b1, "R7 idle ignored");
      drive(1, '0, '1, 0, 0, (k == RUN) ? 1'b0 : 1'b1, "R7 run across idle");
    end
    check(smp_ready, 1'b1, "R10 ready stays high");

    // R4 excluded channel 5 carries signal
    drive(1, one_ch(5, 24'h123456), 6'b000011, 0, 0, 1'b1, "R9 mask change");
    for (int k = 1; k <= RUN; k++)
      drive(1, one_ch(5, 24'h123456), 6'b000011, 0, 0, (k == RUN) ? 1'b0 : 1'b1, "R4 excluded ignored");

    // R3 pin mode: channel 5 now participates, mask ignored
    drive(1, one_ch(5, 24'h123456), 6'b000000, 1, 0, 1'b1, "R9 mode change");
    for (int k = 0; k < 50; k++)
      drive(1, one_ch(5, 24'h123456), 6'b000000, 1, 0, 1'b1, "R3 all channels take part");
    for (int k = 1; k <= RUN; k++)
      drive(1, '0, 6'b000000, 1, 0, (k == RUN) ? 1'b0 : 1'b1, "R3 mask ignored");

    // R9 mask change mid-run forces a full restart
    drive(1, '0, '1, 0, 0, 1'b1, "R9 mode back");
    for (int k = 1; k <= 5000; k++)
      drive(1, '0, '1, 0, 0, 1'b1, "R9 partial run");
    drive(1, '0, 6'b111110, 0, 0, 1'b1, "R9 change frame not counted");
    for (int k = 1; k <= RUN; k++)
      drive(1, '0, 6'b111110, 0, 0, (k == RUN) ? 1'b0 : 1'b1, "R9 full restart");

    // R8 empty mask in register mode
    for (int k = 0; k < RUN + 20; k++)
      drive(1, '0, 6'b000000, 0, 0, 1'b1, "R8 empty mask");

    // R5 mute overrides signal
    for (int k = 0; k < 3; k++)
      drive(1, one_ch(1, 24'h7fffff), '1, 0, 1, 1'b0, "R5 mute forces low");
    drive(1, one_ch(1, 24'h7fffff), '1, 0, 0, 1'b1, "R6 mute released");

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule